// File: doc/BRIEF.md
# Vector Operation Sequencer

This block runs one memory-to-memory vector instruction. A single start pulse hands it an operation code, three base addresses (first operand, second operand, destination) and an element count. The block then walks an index upward from zero. For each index it fetches the two operand elements, combines them and stores the result at the matching destination slot. It finishes when the index equals the count. One instruction of this kind stands in for a software loop of scalar instructions.

The block owns the only port of a single-port synchronous RAM. The RAM returns read data one cycle after the read request. Each element therefore takes a read of operand 1, a read of operand 2 and a write. A plain copy needs no second operand, so it uses two cycles per element instead of three. Element addresses are the base plus the index, taken modulo the 8-bit address space, so vectors may wrap past the top of memory.

Top module: `vecseq_top`

## Requirements
- R1: After reset, `busy`, `done`, `memRe` and `memWe` are low, and no memory access is made while `busy` is low.
- R2: The block samples `start` only while idle, latching `opcode`, the three bases and `count` at that edge. A `start` pulse while busy, including the cycle in which `done` is high, is ignored and leaves the running instruction unchanged.
- R3: For each index i below the count, the block writes, at address `dstBase`+i, the value a op b, where a is the word at `src1Base`+i and b is the word at `src2Base`+i. The opcode encodings are 0 copy a, 1 a+b, 2 a-b, 3 a AND b, 4 a OR b and 5 a XOR b, with sums and differences taken modulo 2^16. Codes 6 and 7 write zero.
- R4: Elements are handled in ascending index order, and every element's reads complete before its write. When the vectors overlap, a later element therefore reads values written by earlier ones. Address sums wrap modulo 256.
- R5: A copy (code 0) never reads operand 2 and takes 2 cycles per element. Every other code takes 3 cycles per element. `done` is high N*k+1 cycles after the clock edge that accepted `start`, where k is the per-element cycle count.
- R6: A count of zero makes no memory access, and `done` rises in the cycle right after the accepting edge.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle inclusive.
- R8: An instruction with count N makes exactly N memory writes.
- R9: `memRe` and `memWe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, honoured only while idle |
| opcode | input | 3 | Operation code |
| src1Base | input | 8 | Address of operand 1 element 0 |
| src2Base | input | 8 | Address of operand 2 element 0 |
| dstBase | input | 8 | Address of result element 0 |
| count | input | 9 | Number of elements |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | 8 | RAM address |
| memRe | output | 1 | RAM read request, data returned next cycle |
| memWe | output | 1 | RAM write strobe |
| memWdata | output | 16 | RAM write data |
| memRdata | input | 16 | RAM read data |

## Verification
Two events can fall in the same cycle. The first is a new `start` arriving during the completion cycle, while `done` is high. The second is a write to a slot that the very next element reads from. The bench raises `start` at the exact cycle `done` is seen, and also in the middle of a run. It judges both by whether `busy` stays low afterwards and by whether the stream of writes matches a sequential reference model exactly. The overlap case runs a copy whose destination is the source shifted by one. The expected result is that the first element propagates through the whole destination, which holds only if each write lands before the following read.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_MOVE = 3'd0;
  localparam logic [OP_W-1:0] OP_ADD  = 3'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 3'd2;
  localparam logic [OP_W-1:0] OP_AND  = 3'd3;
  localparam logic [OP_W-1:0] OP_OR   = 3'd4;
  localparam logic [OP_W-1:0] OP_XOR  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_WR,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    ADR_SRC1,
    ADR_SRC2,
    ADR_DST
  } adrSel_t;

  typedef struct packed {
    logic    load;
    logic    capOp1;
    logic    incIdx;
    logic    memRe;
    logic    memWe;
    adrSel_t adrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/vecseq_alu.sv
module vecseq_alu
  import vecseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    case (opSel)
      OP_MOVE: result = opA;
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/vecseq_ctrl.sv
module vecseq_ctrl
  import vecseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inCountZero,
  input  logic        moveOp,
  input  logic        lastElem,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    strobe        = '0;
    strobe.adrSel = ADR_SRC1;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = inCountZero ? ST_DONE : ST_RD1;
        end
      end
      ST_RD1: begin
        strobe.memRe  = 1'b1;
        strobe.adrSel = ADR_SRC1;
        nextState     = moveOp ? ST_WR : ST_RD2;
      end
      ST_RD2: begin
        strobe.memRe  = 1'b1;
        strobe.adrSel = ADR_SRC2;
        strobe.capOp1 = 1'b1;
        nextState     = ST_WR;
      end
      ST_WR: begin
        strobe.memWe  = 1'b1;
        strobe.adrSel = ADR_DST;
        strobe.incIdx = 1'b1;
        nextState     = lastElem ? ST_DONE : ST_RD1;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/vecseq_dp.sv
module vecseq_dp
  import vecseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [OP_W-1:0]   opcodeIn,
  input  logic [ADDR_W-1:0] src1In,
  input  logic [ADDR_W-1:0] src2In,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              inCountZero,
  output logic              moveOp,
  output logic              lastElem
);

  logic [OP_W-1:0]   opReg;
  logic [ADDR_W-1:0] src1Reg, src2Reg, dstReg;
  logic [CNT_W-1:0]  cntReg, idx;
  logic [DATA_W-1:0] op1Reg;
  logic [CNT_W-1:0]  idxNext;
  logic [ADDR_W-1:0] idxLow;
  logic [DATA_W-1:0] aluA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= '0;
      src1Reg <= '0;
      src2Reg <= '0;
      dstReg  <= '0;
      cntReg  <= '0;
    end else if (strobe.load) begin
      opReg   <= opcodeIn;
      src1Reg <= src1In;
      src2Reg <= src2In;
      dstReg  <= dstIn;
      cntReg  <= countIn;
    end
  end

  assign idxNext = idx + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idx <= '0;
    else if (strobe.load)   idx <= '0;
    else if (strobe.incIdx) idx <= idxNext;
  end

  // operand 1 is held while operand 2 is being fetched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              op1Reg <= '0;
    else if (strobe.capOp1) op1Reg <= memRdata;
  end

  assign idxLow = idx[ADDR_W-1:0];

  always_comb begin
    case (strobe.adrSel)
      ADR_SRC1: memAddr = src1Reg + idxLow;
      ADR_SRC2: memAddr = src2Reg + idxLow;
      ADR_DST:  memAddr = dstReg + idxLow;
      default:  memAddr = src1Reg + idxLow;
    endcase
  end

  assign moveOp      = (opReg == OP_MOVE);
  assign inCountZero = (countIn == '0);
  assign lastElem    = (idxNext == cntReg);

  // a copy writes the word read one cycle earlier
  assign aluA = moveOp ? memRdata : op1Reg;

  vecseq_alu #(.DATA_W(DATA_W)) uAlu (
    .opSel (opReg),
    .opA   (aluA),
    .opB   (memRdata),
    .result(memWdata)
  );

endmodule

// File: rtl/vecseq_top.sv
module vecseq_top
  import vecseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [ADDR_W-1:0] src1Base,
  input  logic [ADDR_W-1:0] src2Base,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  ctrlStrobe_t strobe;
  logic        inCountZero, moveOp, lastElem;

  vecseq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .inCountZero(inCountZero),
    .moveOp     (moveOp),
    .lastElem   (lastElem),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  vecseq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opcodeIn   (opcode),
    .src1In     (src1Base),
    .src2In     (src2Base),
    .dstIn      (dstBase),
    .countIn    (count),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .inCountZero(inCountZero),
    .moveOp     (moveOp),
    .lastElem   (lastElem)
  );

  assign memRe = strobe.memRe;
  assign memWe = strobe.memWe;

endmodule

// File: rtl/vecseq_chk.sv
module vecseq_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             busy,
  input logic             done,
  input logic             memRe,
  input logic             memWe
);

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && count == '0) |=> (done && !memRe && !memWe));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRe && !memWe));

endmodule

bind vecseq_top vecseq_chk #(.CNT_W(CNT_W)) uChk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .count(count),
  .busy (busy),
  .done (done),
  .memRe(memRe),
  .memWe(memWe)
);

// File: tb/sim_vecseq_top.sv
`timescale 1ns/1ps
module sim_vecseq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic [7:0]  src1Base = '0, src2Base = '0, dstBase = '0;
  logic [8:0]  count = '0;
  logic        busy, done, memRe, memWe;
  logic [7:0]  memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  int checks = 0;
  int errors = 0;
  int writeCnt = 0;
  bit finished = 1'b0;
  string curReq = "R3";

  logic [15:0] ram [256];
  logic [15:0] shadow [256];
  logic [23:0] expQ [$];

  always #2.5 clk = ~clk;

  vecseq_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .src1Base(src1Base), .src2Base(src2Base), .dstBase(dstBase),
    .count(count), .busy(busy), .done(done), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

  // single-port RAM, read data one cycle after the request
  always @(posedge clk) begin
    if (memWe) ram[memAddr] <= memWdata;
    if (memRe) memRdata <= ram[memAddr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refOp(input logic [2:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    case (op)
      3'd0: return a;
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      default: return 16'h0;
    endcase
  endfunction

  // scoreboard monitor: every write is compared with the next expected item
  always @(negedge clk) begin
    if (rstN && memWe) begin
      writeCnt++;
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected write", int'(memAddr), 0);
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        check(memAddr == e[23:16] && memWdata == e[15:0], curReq,
              int'({memAddr, memWdata}), int'(e));
      end
    end
  end

  task automatic runVec(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] d, input int n, input string req,
                        input int pokeAt, input bit pokeDone);
    int lat;
    int expLat;
    int w0;
    curReq = req;
    for (int i = 0; i < n; i++) begin
      logic [7:0]  ia, ib, id;
      logic [15:0] r;
      ia = a + 8'(i);
      ib = b + 8'(i);
      id = d + 8'(i);
      r = refOp(op, shadow[ia], shadow[ib]);
      shadow[id] = r;
      expQ.push_back({id, r});
    end
    expLat = (n == 0) ? 1 : n * ((op == 3'd0) ? 2 : 3) + 1;
    w0 = writeCnt;
    @(negedge clk);
    opcode = op; src1Base = a; src2Base = b; dstBase = d; count = 9'(n);
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
      end
      if (lat == pokeAt) begin
        // R2: a launch request mid-run must be ignored
        start = 1'b1; opcode = 3'd1; src1Base = 8'h11; dstBase = 8'h22; count = 9'd3;
      end
      if (lat == pokeAt + 1) start = 1'b0;
    end while (!done && lat < 3000);
    start = 1'b0;
    check(lat == expLat, "R5 latency", lat, expLat);
    check(expQ.size() == 0, "R4 all writes seen", expQ.size(), 0);
    check(writeCnt - w0 == n, "R8 write count", writeCnt - w0, n);
    if (pokeDone) begin
      // R2: request in the done cycle is ignored
      start = 1'b1; opcode = 3'd1; count = 9'd2;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0 && done == 1'b0, "R2 start during done", int'({busy, done}), 0);
      @(negedge clk);
      check(busy == 1'b0 && writeCnt - w0 == n, "R2 no relaunch", int'(busy), 0);
    end else begin
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R7 done one cycle", int'({busy, done}), 0);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #750000;
    check(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 16'(i * 40503 + 7) ^ 16'(i << 5);
      shadow[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && memWe == 0 && memRe == 0, "R1 reset state",
          int'({busy, done, memWe, memRe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && memWe == 0 && memRe == 0, "R1 idle quiet",
          int'({busy, memWe, memRe}), 0);

    runVec(3'd1, 8'h00, 8'h10, 8'h60, 5, "R3 add", -5, 1'b0);
    runVec(3'd2, 8'h20, 8'h30, 8'h68, 4, "R3 sub", -5, 1'b0);
    runVec(3'd3, 8'h05, 8'h15, 8'h70, 3, "R3 and", -5, 1'b0);
    runVec(3'd4, 8'h06, 8'h16, 8'h74, 3, "R3 or", -5, 1'b0);
    runVec(3'd5, 8'h07, 8'h17, 8'h78, 3, "R3 xor", -5, 1'b0);
    runVec(3'd0, 8'h20, 8'hAA, 8'h90, 6, "R5 move", -5, 1'b0);
    runVec(3'd7, 8'h01, 8'h02, 8'hA0, 2, "R3 undefined code", -5, 1'b0);
    runVec(3'd1, 8'h00, 8'h00, 8'hB0, 0, "R6 zero count", -5, 1'b0);
    runVec(3'd0, 8'h40, 8'h00, 8'h41, 4, "R4 overlap move", -5, 1'b0);
    runVec(3'd1, 8'hFE, 8'h50, 8'hFD, 4, "R4 wrap", -5, 1'b0);
    runVec(3'd5, 8'h30, 8'h31, 8'hC0, 4, "R2 start while busy", 3, 1'b0);
    runVec(3'd2, 8'h33, 8'h44, 8'hD0, 2, "R2 start at done", -5, 1'b1);
    runVec(3'd1, 8'h10, 8'h10, 8'h10, 3, "R3 in place", -5, 1'b0);
    finish();
  end

endmodule